// File: doc/BRIEF.md
# Asynchronous Memory Strobe Sequencer with Wait Stretch

This block times one access to an external asynchronous memory. Each access is a read or a write. It runs through three phases: setup, strobe and hold. Each phase lasts a programmable number of clock cycles, and reads and writes have separate sets of counts. Chip select covers all three phases. Output-enable marks the strobe of a read, and write-enable marks the strobe of a write. A one-cycle done pulse marks the last cycle of every access.

When extended waiting is enabled, the attached device can stretch the strobe through a wait pin whose active level is programmable. The pin passes through a synchroniser and is looked at in the final programmed strobe cycle. While it stays active, extension cycles are added. Once it drops, the sequencer replays that final strobe cycle and then moves to hold. A per-access limit caps the number of extension cycles. When the limit runs out, the sequencer goes to hold whatever the pin level, and it can latch a sticky timeout interrupt.

Top module: `amem_strobe_seq`

## Requirements
- R1: Once a request is accepted in idle, `cs_n` stays low for exactly eff(setup) + strobe length + eff(hold) consecutive cycles, where eff(n) is n, or 1 when n is 0. The read counts apply when `req_write`=0 and the write counts when `req_write`=1.
- R2: `oe_n` is low only during the strobe of a read and `we_n` only during the strobe of a write. Both are low only while `cs_n` is low, and never at the same time. Without extension the strobe lasts eff(strobe count) cycles.
- R3: When `ext_wait_en`=0, the wait pin has no effect and the strobe keeps its programmed length.
- R4: The wait pin is active when its level equals `wait_pol`: 1 means active-high, 0 means active-low. At the inactive level it never stretches the strobe.
- R5: Waiting applies to an access only if its raw setup count plus its raw strobe count is greater than 4. Otherwise the pin is ignored for that access.
- R6: The pin is seen through a two-stage synchroniser, so the sequencer acts on the level the pin had two clock edges earlier. If that level is active in the final programmed strobe cycle, extension cycles follow. The first extension cycle that sees it inactive is followed by one more strobe cycle and then hold. With the pin released after strobe cycle X, for eff(strobe)-1 <= X <= eff(strobe)+`max_ext`-2, the strobe lasts X+3 cycles.
- R7: An access never has more than `max_ext` extension cycles. If the pin is still active in the last one allowed, hold follows and the strobe lasts eff(strobe)+`max_ext` cycles. With `max_ext`=0 no extension takes place.
- R8: `tmo_irq` sets when a limit expiry occurs while `tmo_irq_en`=1. It stays set until a cycle with `tmo_clr`=1 and no new expiry. An expiry with `tmo_irq_en`=0 leaves it clear.
- R9: `done` is high for exactly one cycle per access, in the final cycle of `cs_n` low. `req_valid` is ignored while an access is in progress.
- R10: The extension counter restarts at every access, so back-to-back accesses each get the full `max_ext` allowance.
- R11: During `rst` (synchronous, active-high), `cs_n`, `oe_n` and `we_n` are high and `done` and `tmo_irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request, taken only in idle |
| req_write | input | 1 | 1 = write access, 0 = read access |
| rd_setup | input | CNT_W | Read setup cycles |
| rd_strobe | input | CNT_W | Read strobe cycles |
| rd_hold | input | CNT_W | Read hold cycles |
| wr_setup | input | CNT_W | Write setup cycles |
| wr_strobe | input | CNT_W | Write strobe cycles |
| wr_hold | input | CNT_W | Write hold cycles |
| ext_wait_en | input | 1 | Enables strobe stretching by the wait pin |
| wait_pol | input | 1 | Active level of the wait pin |
| max_ext | input | EXT_W | Maximum extension cycles per access |
| tmo_irq_en | input | 1 | Allows a limit expiry to set the interrupt |
| tmo_clr | input | 1 | Clears the timeout interrupt |
| wait_pin | input | 1 | Asynchronous wait request from the device |
| cs_n | output | 1 | Chip select, active low |
| oe_n | output | 1 | Output enable, active low |
| we_n | output | 1 | Write enable, active low |
| done | output | 1 | One-cycle pulse in the last cycle of an access |
| tmo_irq | output | 1 | Sticky timeout interrupt |

## Verification
The main function is exercised with the pin held inactive, held active, and released at chosen strobe cycles. One release comes early enough that it never stretches the strobe, one comes right at the edge of the synchroniser latency, one comes mid-extension, and one comes too late to beat the limit. Each of these separates normal completion, replay of the final strobe cycle and forced hold. Other patterns cover both polarities, disabled waiting, setup+strobe sums of 4 and 5, and limits of 0 and small values. They show that the enable, polarity and qualification gates each block or allow stretching on their own. Zero counts, a request injected mid-access, repeated timeouts and a timeout with the interrupt masked cover the remaining corner cases.

// File: rtl/amem_pkg.sv
package amem_pkg;

    localparam int unsigned DEF_CNT_W    = 4;
    localparam int unsigned DEF_EXT_W    = 8;
    localparam int unsigned SYNC_STAGES  = 2;
    localparam int unsigned WAIT_MIN_SUM = 4;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_EXTEND,
        PH_HOLD
    } phase_e;

    // per-access control captured when the request is taken
    typedef struct packed {
        logic is_wr;
        logic wait_ok;
        logic resumed;
    } acc_ctl_t;

    function automatic logic wait_qualified(int unsigned setup_cyc, int unsigned strobe_cyc);
        return (setup_cyc + strobe_cyc) > WAIT_MIN_SUM;
    endfunction

endpackage

// File: rtl/amem_wait_sync.sv
module amem_wait_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= din;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/amem_phase_cnt.sv
module amem_phase_cnt #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         last
);
    localparam logic [W-1:0] ONE = 1;
    logic [W-1:0] cnt;

    // a count of zero behaves as one cycle
    always_ff @(posedge clk) begin
        if (rst)               cnt <= '0;
        else if (load)         cnt <= (load_val == '0) ? '0 : load_val - ONE;
        else if (cnt != '0)    cnt <= cnt - ONE;
    end

    assign last = (cnt == '0);
endmodule

// File: rtl/amem_ext_limit.sv
module amem_ext_limit #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    input  logic [W-1:0] max_ext,
    output logic [W-1:0] ext_cnt,
    output logic         none_allowed,
    output logic         used_up
);
    localparam logic [W-1:0] ONE   = 1;
    localparam logic [W:0]   ONE_X = 1;

    always_ff @(posedge clk) begin
        if (rst || clr) ext_cnt <= '0;
        else if (inc)   ext_cnt <= ext_cnt + ONE;
    end

    assign none_allowed = (max_ext == '0);
    // true in the extension cycle that is the last one allowed
    assign used_up      = ({1'b0, ext_cnt} + ONE_X) >= {1'b0, max_ext};
endmodule

// File: rtl/amem_strobe_seq.sv
module amem_strobe_seq
    import amem_pkg::*;
#(
    parameter int unsigned CNT_W  = DEF_CNT_W,
    parameter int unsigned EXT_W  = DEF_EXT_W,
    parameter int unsigned SYNC_N = SYNC_STAGES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [CNT_W-1:0] rd_setup,
    input  logic [CNT_W-1:0] rd_strobe,
    input  logic [CNT_W-1:0] rd_hold,
    input  logic [CNT_W-1:0] wr_setup,
    input  logic [CNT_W-1:0] wr_strobe,
    input  logic [CNT_W-1:0] wr_hold,
    input  logic             ext_wait_en,
    input  logic             wait_pol,
    input  logic [EXT_W-1:0] max_ext,
    input  logic             tmo_irq_en,
    input  logic             tmo_clr,
    input  logic             wait_pin,
    output logic             cs_n,
    output logic             oe_n,
    output logic             we_n,
    output logic             done,
    output logic             tmo_irq
);
    phase_e           state_q, state_d;
    acc_ctl_t         ctl_q, ctl_d;
    logic [CNT_W-1:0] strobe_q, hold_q;
    logic [EXT_W-1:0] max_ext_q;
    logic [EXT_W-1:0] ext_cnt;
    logic             wait_s, wait_act;
    logic             cnt_load, cnt_last;
    logic [CNT_W-1:0] cnt_val;
    logic             accept, ext_inc, none_allowed, used_up;
    logic             tmo_set, tmo_q;

    amem_wait_sync #(.STAGES(SYNC_N)) u_sync (
        .clk(clk), .rst(rst), .din(wait_pin), .dout(wait_s)
    );

    amem_phase_cnt #(.W(CNT_W)) u_phase (
        .clk(clk), .rst(rst), .load(cnt_load), .load_val(cnt_val), .last(cnt_last)
    );

    amem_ext_limit #(.W(EXT_W)) u_limit (
        .clk(clk), .rst(rst), .clr(accept), .inc(ext_inc), .max_ext(max_ext_q),
        .ext_cnt(ext_cnt), .none_allowed(none_allowed), .used_up(used_up)
    );

    assign accept   = (state_q == PH_IDLE) && req_valid;
    assign wait_act = ctl_q.wait_ok && !ctl_q.resumed && (wait_s == wait_pol);

    always_comb begin
        state_d  = state_q;
        ctl_d    = ctl_q;
        cnt_load = 1'b0;
        cnt_val  = hold_q;
        ext_inc  = 1'b0;
        tmo_set  = 1'b0;
        done     = 1'b0;
        unique case (state_q)
            PH_IDLE: if (req_valid) begin
                state_d       = PH_SETUP;
                cnt_load      = 1'b1;
                cnt_val       = req_write ? wr_setup : rd_setup;
                ctl_d.is_wr   = req_write;
                ctl_d.resumed = 1'b0;
                ctl_d.wait_ok = ext_wait_en && (req_write
                                ? wait_qualified(32'(wr_setup), 32'(wr_strobe))
                                : wait_qualified(32'(rd_setup), 32'(rd_strobe)));
            end
            PH_SETUP: if (cnt_last) begin
                state_d  = PH_STROBE;
                cnt_load = 1'b1;
                cnt_val  = strobe_q;
            end
            PH_STROBE: if (cnt_last) begin
                if (wait_act && !none_allowed) begin
                    state_d = PH_EXTEND;
                end else begin
                    state_d  = PH_HOLD;
                    cnt_load = 1'b1;
                    tmo_set  = wait_act;
                end
            end
            PH_EXTEND: begin
                if (!wait_act) begin
                    state_d       = PH_STROBE;
                    ctl_d.resumed = 1'b1;
                end else if (used_up) begin
                    state_d  = PH_HOLD;
                    cnt_load = 1'b1;
                    tmo_set  = 1'b1;
                end else begin
                    ext_inc = 1'b1;
                end
            end
            PH_HOLD: if (cnt_last) begin
                state_d = PH_IDLE;
                done    = 1'b1;
            end
            default: state_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= PH_IDLE;
            ctl_q     <= '0;
            strobe_q  <= '0;
            hold_q    <= '0;
            max_ext_q <= '0;
        end else begin
            state_q <= state_d;
            ctl_q   <= ctl_d;
            if (accept) begin
                strobe_q  <= req_write ? wr_strobe : rd_strobe;
                hold_q    <= req_write ? wr_hold : rd_hold;
                max_ext_q <= max_ext;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                       tmo_q <= 1'b0;
        else if (tmo_set && tmo_irq_en) tmo_q <= 1'b1;
        else if (tmo_clr)               tmo_q <= 1'b0;
    end

    assign tmo_irq = tmo_q;
    assign cs_n    = (state_q == PH_IDLE);
    assign oe_n    = !(((state_q == PH_STROBE) || (state_q == PH_EXTEND)) && !ctl_q.is_wr);
    assign we_n    = !(((state_q == PH_STROBE) || (state_q == PH_EXTEND)) && ctl_q.is_wr);
endmodule

// File: rtl/amem_strobe_seq_chk.sv
module amem_strobe_seq_chk #(
    parameter int unsigned EXT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             cs_n,
    input logic             oe_n,
    input logic             we_n,
    input logic             done,
    input logic             tmo_irq,
    input logic             tmo_clr,
    input logic             tmo_irq_en,
    input logic [EXT_W-1:0] ext_cnt,
    input logic [EXT_W-1:0] max_ext_q
);
    assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (rst)
        !(!oe_n && !we_n));

    assert_strobe_in_cs_R2: assert property (@(posedge clk) disable iff (rst)
        (!oe_n || !we_n) |-> !cs_n);

    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_last_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> cs_n);

    assert_done_in_cs_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> !cs_n);

    assert_ext_cap_R7: assert property (@(posedge clk) disable iff (rst)
        ext_cnt <= max_ext_q);

    assert_tmo_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (tmo_irq && !tmo_clr) |=> tmo_irq);

    assert_tmo_gated_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(tmo_irq) |-> $past(tmo_irq_en));

    assert_reset_idle_R11: assert property (@(posedge clk)
        rst |=> (cs_n && oe_n && we_n && !tmo_irq));
endmodule

bind amem_strobe_seq amem_strobe_seq_chk #(.EXT_W(EXT_W)) chk_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n), .done(done),
    .tmo_irq(tmo_irq), .tmo_clr(tmo_clr), .tmo_irq_en(tmo_irq_en),
    .ext_cnt(ext_cnt), .max_ext_q(max_ext_q)
);

// File: tb/amem_strobe_seq_tb_top.sv
module amem_strobe_seq_tb_top;
    localparam int CW = 4;
    localparam int EW = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst, req_valid, req_write, ext_wait_en, wait_pol, tmo_irq_en, tmo_clr, wait_pin;
    logic [CW-1:0] rd_setup, rd_strobe, rd_hold, wr_setup, wr_strobe, wr_hold;
    logic [EW-1:0] max_ext;
    logic          cs_n, oe_n, we_n, done, tmo_irq;

    amem_strobe_seq #(.CNT_W(CW), .EXT_W(EW)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .rd_setup(rd_setup), .rd_strobe(rd_strobe), .rd_hold(rd_hold),
        .wr_setup(wr_setup), .wr_strobe(wr_strobe), .wr_hold(wr_hold),
        .ext_wait_en(ext_wait_en), .wait_pol(wait_pol), .max_ext(max_ext),
        .tmo_irq_en(tmo_irq_en), .tmo_clr(tmo_clr), .wait_pin(wait_pin),
        .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n), .done(done), .tmo_irq(tmo_irq)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    // mode: 0 pin held inactive, 1 pin held active, 2 pin released after strobe cycle rel
    typedef struct packed {
        logic       wr;
        logic [3:0] s;
        logic [3:0] t;
        logic [3:0] h;
        logic       ext;
        logic       pol;
        logic [7:0] mx;
        logic [1:0] mode;
        logic [7:0] rel;
        logic [7:0] exp_strobe;
        logic       exp_tmo;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 4'd2, 4'd3, 4'd2, 1'b0, 1'b1, 8'd4, 2'd1, 8'd0, 8'd3, 1'b0}, // R3 disabled
        '{1'b1, 4'd2, 4'd3, 4'd1, 1'b1, 1'b1, 8'd4, 2'd0, 8'd0, 8'd3, 1'b0}, // R2 plain write
        '{1'b0, 4'd2, 4'd3, 4'd2, 1'b1, 1'b1, 8'd4, 2'd1, 8'd0, 8'd7, 1'b1}, // R7 timeout
        '{1'b1, 4'd1, 4'd4, 4'd2, 1'b1, 1'b0, 8'd5, 2'd1, 8'd0, 8'd9, 1'b1}, // R4 active low
        '{1'b0, 4'd2, 4'd4, 4'd1, 1'b1, 1'b0, 8'd5, 2'd0, 8'd0, 8'd4, 1'b0}, // R4 high = idle
        '{1'b0, 4'd2, 4'd2, 4'd1, 1'b1, 1'b1, 8'd5, 2'd1, 8'd0, 8'd2, 1'b0}, // R5 sum 4
        '{1'b1, 4'd3, 4'd2, 4'd1, 1'b1, 1'b1, 8'd6, 2'd1, 8'd0, 8'd8, 1'b1}, // R5 sum 5
        '{1'b0, 4'd2, 4'd4, 4'd2, 1'b1, 1'b1, 8'd8, 2'd2, 8'd5, 8'd8, 1'b0}, // R6 mid release
        '{1'b0, 4'd2, 4'd4, 4'd2, 1'b1, 1'b1, 8'd8, 2'd2, 8'd2, 8'd4, 1'b0}, // R6 early release
        '{1'b1, 4'd2, 4'd3, 4'd2, 1'b1, 1'b1, 8'd0, 2'd1, 8'd0, 8'd3, 1'b1}, // R7 zero limit
        '{1'b0, 4'd2, 4'd4, 4'd1, 1'b1, 1'b1, 8'd3, 2'd2, 8'd6, 8'd7, 1'b1}, // R7 late release
        '{1'b0, 4'd2, 4'd4, 4'd2, 1'b1, 1'b1, 8'd8, 2'd2, 8'd3, 8'd6, 1'b0}  // R6 edge release
    };

    function automatic string vtag(input int i);
        case (i)
            0:          return "R3";
            1:          return "R2";
            3, 4:       return "R4";
            5, 6:       return "R5";
            7, 8, 11:   return "R6";
            default:    return "R7";
        endcase
    endfunction

    task automatic run_access(
        input  logic wr, input int s, input int t, input int h,
        input  logic ext, input logic pol, input int mx, input int mode, input int rel,
        input  logic irq_en, input logic inject,
        output int cs_cnt, output int strobe_cnt, output int wrong_cnt,
        output int done_cnt, output int done_at);
        @(negedge clk);
        req_write   = wr;
        rd_setup    = wr ? 4'd7 : 4'(s);
        rd_strobe   = wr ? 4'd7 : 4'(t);
        rd_hold     = wr ? 4'd7 : 4'(h);
        wr_setup    = wr ? 4'(s) : 4'd7;
        wr_strobe   = wr ? 4'(t) : 4'd7;
        wr_hold     = wr ? 4'(h) : 4'd7;
        ext_wait_en = ext;
        wait_pol    = pol;
        max_ext     = 8'(mx);
        tmo_irq_en  = irq_en;
        wait_pin    = (mode == 0) ? ~pol : pol;
        repeat (4) @(negedge clk);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid  = 1'b0;
        cs_cnt     = 0;
        strobe_cnt = 0;
        wrong_cnt  = 0;
        done_cnt   = 0;
        done_at    = -1;
        for (int k = 0; k < 400; k++) begin
            if (cs_n) break;
            cs_cnt++;
            if (wr ? !we_n : !oe_n) strobe_cnt++;
            if (wr ? !oe_n : !we_n) wrong_cnt++;
            if (done) begin
                done_cnt++;
                done_at = cs_cnt;
            end
            if (mode == 2 && strobe_cnt == rel) wait_pin = ~pol;
            if (inject && cs_cnt == 2) begin
                req_valid = 1'b1;
                req_write = ~wr;
            end else begin
                req_valid = 1'b0;
                req_write = wr;
            end
            @(negedge clk);
        end
        req_valid = 1'b0;
        wait_pin  = ~pol;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int cs, st, wrong, dn, dat;
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; ext_wait_en = 1'b0;
        wait_pol = 1'b1; tmo_irq_en = 1'b1; tmo_clr = 1'b0; wait_pin = 1'b0;
        rd_setup = '0; rd_strobe = '0; rd_hold = '0;
        wr_setup = '0; wr_strobe = '0; wr_hold = '0; max_ext = '0;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 cs_n in reset", int'(cs_n), 1);
        chk("R11 oe_n in reset", int'(oe_n), 1);
        chk("R11 we_n in reset", int'(we_n), 1);
        chk("R11 done in reset", int'(done), 0);
        chk("R11 tmo_irq in reset", int'(tmo_irq), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R11 cs_n after reset", int'(cs_n), 1);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VECS[i];
            run_access(v.wr, int'(v.s), int'(v.t), int'(v.h), v.ext, v.pol, int'(v.mx),
                       int'(v.mode), int'(v.rel), 1'b1, 1'b0, cs, st, wrong, dn, dat);
            chk($sformatf("%s vec%0d strobe length", vtag(i), i), st, int'(v.exp_strobe));
            chk($sformatf("R1 vec%0d cs length", i), cs,
                eff(int'(v.s)) + int'(v.exp_strobe) + eff(int'(v.h)));
            chk($sformatf("R2 vec%0d wrong strobe", i), wrong, 0);
            chk($sformatf("R9 vec%0d done count", i), dn, 1);
            chk($sformatf("R9 vec%0d done position", i), dat, cs);
            repeat (2) @(negedge clk);
            chk($sformatf("R8 vec%0d timeout flag", i), int'(tmo_irq), int'(v.exp_tmo));
            tmo_clr = 1'b1;
            @(negedge clk);
            tmo_clr = 1'b0;
            chk($sformatf("R8 vec%0d timeout cleared", i), int'(tmo_irq), 0);
        end

        // R1 zero counts behave as one cycle each
        run_access(1'b1, 0, 0, 0, 1'b0, 1'b1, 4, 0, 0, 1'b1, 1'b0, cs, st, wrong, dn, dat);
        chk("R1 zero counts strobe", st, 1);
        chk("R1 zero counts cs", cs, 3);

        // R8 masked expiry: strobe still capped, flag stays clear
        run_access(1'b0, 2, 3, 2, 1'b1, 1'b1, 4, 1, 0, 1'b0, 1'b0, cs, st, wrong, dn, dat);
        chk("R8 masked expiry strobe", st, 7);
        repeat (2) @(negedge clk);
        chk("R8 masked expiry flag", int'(tmo_irq), 0);

        // R10 back-to-back expiries each get the full allowance
        run_access(1'b0, 2, 3, 2, 1'b1, 1'b1, 4, 1, 0, 1'b1, 1'b0, cs, st, wrong, dn, dat);
        chk("R10 first expiry strobe", st, 7);
        run_access(1'b0, 2, 3, 2, 1'b1, 1'b1, 4, 1, 0, 1'b1, 1'b0, cs, st, wrong, dn, dat);
        chk("R10 second expiry strobe", st, 7);
        repeat (2) @(negedge clk);
        chk("R8 flag held across accesses", int'(tmo_irq), 1);
        tmo_clr = 1'b1;
        @(negedge clk);
        tmo_clr = 1'b0;

        // R9 request during an access is ignored
        run_access(1'b0, 2, 3, 2, 1'b0, 1'b1, 4, 0, 0, 1'b1, 1'b1, cs, st, wrong, dn, dat);
        chk("R9 inject cs length", cs, 7);
        chk("R9 inject no write strobe", wrong, 0);
        cs = 0;
        for (int k = 0; k < 4; k++) begin
            if (!cs_n) cs++;
            @(negedge clk);
        end
        chk("R9 inject no follow-on access", cs, 0);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule